// File: doc/BRIEF.md
# Descriptor-Driven Memory Transfer Controller

This block is a small transfer engine that moves single data units between memory locations on behalf of up to 24 request lines. It keeps no per-source transfer parameters of its own. When a request line is served, the engine reads a pointer from a vector table, fetches that source's 8-byte record from memory, moves one byte or one halfword, and writes the updated count and addresses back into the record.

The vector table sits at the 256-byte page selected by an 8-bit base register. A record can ask to be chained, and the engine then runs the record that follows it in memory within the same activation. Each record selects either normal counting, which signals completion when its count is used up, or repeat counting, which rewinds the count and the block automatically.

The memory port is a simple synchronous master: read data returns on the cycle after a read strobe.

Top module: `desc_xfer`

## Requirements
- R1: After reset the base register reads back 0xFD, all `done` lines are low, and `mem_rd` and `mem_wr` are both low.
- R2: Source k's record pointer is the little-endian halfword at address {base, 8'h00} + 2k. A record holds eight bytes. Offset 0 is the control byte and offset 1 the block size. Offsets 2, 4 and 6 hold the count, the source address and the destination address, each a little-endian halfword.
- R3: The control byte is decoded as follows: bit0 sets the unit width (1 = 16-bit), bit1 selects repeat mode, bit2 makes the source address increment, bit3 makes the destination address increment, and bit4 enables chaining. With 8-bit units, one byte is copied, the count drops by one, an incrementing address advances by 1, and all three fields are written back to the record.
- R4: With 16-bit units, a little-endian halfword is copied and an incrementing address advances by 2.
- R5: An address whose increment bit is 0 is written back unchanged.
- R6: In normal mode, `done[k]` pulses for one cycle when source k's count goes from 1 to 0. No pulse occurs for any other count.
- R7: In repeat mode, when the count goes from 1 to 0 it is reloaded with the block size. Each incrementing address is moved back by block size × unit width, and no `done` pulse occurs.
- R8: When a record's chain bit is 1, the record at the next 8-byte address is executed in the same activation. This continues until a record with the chain bit 0 has executed.
- R9: When several requests are pending, the lowest-numbered source is served first, and every pending request is eventually served.
- R10: A write to the base register takes effect while the engine is idle and is ignored while an activation is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Base register write strobe |
| cfg_wdata | input | 8 | Base register write value |
| cfg_rdata | output | 8 | Base register read value |
| req | input | NSRC | Activation request pulses, one per source |
| done | output | NSRC | Per-source completion pulse |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wide | output | 1 | 1 = halfword access, 0 = byte access in the low lane |
| mem_addr | output | 16 | Byte address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid the cycle after `mem_rd` |

## Verification
The assertions assume a memory that returns data one cycle after a read and accepts writes in the same cycle. They also assume that base register writes come only as single-cycle strobes. The bench memory model follows that timing exactly. It places records, vectors and data areas in disjoint regions, so no transfer overwrites a record or vector it depends on. Count values of zero and block sizes of zero are never used, because the wrap behaviour in those cases is not part of the requirements.

// File: rtl/desc_xfer.sv
module desc_xfer #(
  parameter int NSRC = 24,
  parameter logic [7:0] BASE_RST = 8'hFD
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [7:0]      cfg_wdata,
  output logic [7:0]      cfg_rdata,
  input  logic [NSRC-1:0] req,
  output logic [NSRC-1:0] done,
  output logic            mem_rd,
  output logic            mem_wr,
  output logic            mem_wide,
  output logic [15:0]     mem_addr,
  output logic [15:0]     mem_wdata,
  input  logic [15:0]     mem_rdata
);
  localparam int SW = $clog2(NSRC);

  typedef enum logic [3:0] {
    S_IDLE, S_VEC, S_PTR, S_F0, S_F1, S_F2, S_F3, S_F4, S_XD, S_W1, S_W2, S_W3
  } st_t;

  st_t            st;
  logic [7:0]     base;
  logic [NSRC-1:0] pend;
  logic [SW-1:0]  cur, pick;
  logic [15:0]    rec, cnt, sa, da;
  logic [4:0]     ctl;
  logic [7:0]     blk;
  logic           hit0;

  wire busy  = st != S_IDLE;
  wire start = !busy && |pend;

  always_comb begin
    pick = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (pend[i]) pick = SW'(i);
  end

  wire        lastu = cnt == 16'd1;
  wire        wrap  = ctl[1] && lastu;
  wire [15:0] inc   = ctl[0] ? 16'd2 : 16'd1;
  wire [15:0] span  = ctl[0] ? {7'd0, blk, 1'b0} : {8'd0, blk};
  wire [15:0] step  = inc - (wrap ? span : 16'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; base <= BASE_RST; pend <= '0; cur <= '0;
      rec <= '0; cnt <= '0; sa <= '0; da <= '0; ctl <= '0; blk <= '0; hit0 <= 1'b0;
    end else begin
      pend <= (pend | req) & ~(start ? (NSRC'(1) << pick) : '0);
      if (cfg_we && !busy) base <= cfg_wdata;
      case (st)
        S_IDLE: if (start) begin cur <= pick; st <= S_VEC; end
        S_VEC:  st <= S_PTR;
        S_PTR:  begin rec <= mem_rdata; st <= S_F0; end
        S_F0:   st <= S_F1;
        S_F1:   begin ctl <= mem_rdata[4:0]; blk <= mem_rdata[15:8]; st <= S_F2; end
        S_F2:   begin cnt <= mem_rdata; st <= S_F3; end
        S_F3:   begin sa <= mem_rdata; st <= S_F4; end
        S_F4:   begin da <= mem_rdata; st <= S_XD; end
        S_XD: begin
          cnt  <= wrap ? {8'd0, blk} : cnt - 16'd1;
          if (ctl[2]) sa <= sa + step;
          if (ctl[3]) da <= da + step;
          hit0 <= lastu && !ctl[1];
          st   <= S_W1;
        end
        S_W1: st <= S_W2;
        S_W2: st <= S_W3;
        S_W3: if (ctl[4]) begin rec <= rec + 16'd8; st <= S_F0; end
              else st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    case (st)
      S_VEC:       mem_addr = {base, 8'h00} + {{(15 - SW){1'b0}}, cur, 1'b0};
      S_F0:        mem_addr = rec;
      S_F1, S_W1:  mem_addr = rec + 16'd2;
      S_F2, S_W2:  mem_addr = rec + 16'd4;
      S_F3, S_W3:  mem_addr = rec + 16'd6;
      S_F4:        mem_addr = sa;
      S_XD:        mem_addr = da;
      default:     mem_addr = '0;
    endcase
    case (st)
      S_XD:    mem_wdata = ctl[0] ? mem_rdata : {8'h00, mem_rdata[7:0]};
      S_W1:    mem_wdata = cnt;
      S_W2:    mem_wdata = sa;
      S_W3:    mem_wdata = da;
      default: mem_wdata = '0;
    endcase
  end

  assign mem_rd    = st inside {S_VEC, S_F0, S_F1, S_F2, S_F3, S_F4};
  assign mem_wr    = st inside {S_XD, S_W1, S_W2, S_W3};
  assign mem_wide  = !(st inside {S_F4, S_XD}) || ctl[0];
  assign done      = (st == S_W3 && hit0) ? (NSRC'(1) << cur) : '0;
  assign cfg_rdata = base;
endmodule

module desc_xfer_chk #(parameter int NSRC = 24) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            cfg_we,
  input logic [7:0]      cfg_rdata,
  input logic [NSRC-1:0] done,
  input logic            mem_rd,
  input logic            mem_wr
);
  // R6
  done_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(done));
  // R10
  base_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && busy) |=> $stable(cfg_rdata));
  // R3
  rdwr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(mem_rd && mem_wr));
  // R8
  done_wb_chk: assert property (@(posedge clk) disable iff (!rst_n) (|done) |-> mem_wr);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(mem_wr || mem_rd));
endmodule

bind desc_xfer desc_xfer_chk #(.NSRC(NSRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .cfg_we(cfg_we), .cfg_rdata(cfg_rdata),
  .done(done), .mem_rd(mem_rd), .mem_wr(mem_wr)
);

// File: tb/sim_desc_xfer.sv
module sim_desc_xfer;
  localparam int NSRC = 24;
  logic clk = 0, rst_n = 0, cfg_we = 0;
  logic [7:0] cfg_wdata = 0, cfg_rdata;
  logic [NSRC-1:0] req = '0, done;
  logic mem_rd, mem_wr, mem_wide;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;

  always #5 clk = ~clk;

  desc_xfer #(.NSRC(NSRC)) u0 (.*);

  logic [7:0] mem [4096];
  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem_wide ? {mem[(mem_addr + 16'd1) & 16'hFFF], mem[mem_addr & 16'hFFF]}
                                      : {8'h00, mem[mem_addr & 16'hFFF]};
    if (mem_wr) begin
      mem[mem_addr & 16'hFFF] <= mem_wdata[7:0];
      if (mem_wide) mem[(mem_addr + 16'd1) & 16'hFFF] <= mem_wdata[15:8];
    end
  end

  int dcnt [NSRC];
  always @(posedge clk) for (int i = 0; i < NSRC; i++) if (done[i]) dcnt[i]++;

  int total = 0, bad = 0;
  logic [7:0] bval = 8'hFD;

  task automatic chk(input bit ok, input string r, input string what, input int act, input int exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s %s: actual=%0h expected=%0h", r, what, act, exp); end
  endtask

  task automatic wr16(input logic [15:0] a, input logic [15:0] d);
    mem[a & 16'hFFF] = d[7:0]; mem[(a + 16'd1) & 16'hFFF] = d[15:8];
  endtask
  function automatic logic [15:0] rd16(input logic [15:0] a);
    return {mem[(a + 16'd1) & 16'hFFF], mem[a & 16'hFFF]};
  endfunction

  task automatic put_rec(input logic [15:0] r, input logic [7:0] c, input logic [7:0] b,
                         input logic [15:0] n, input logic [15:0] s, input logic [15:0] d);
    wr16(r, {b, c}); wr16(r + 2, n); wr16(r + 4, s); wr16(r + 6, d);
  endtask
  task automatic put_vec(input int k, input logic [15:0] r);
    wr16({bval, 8'h00} + 16'(2 * k), r);
  endtask
  task automatic pulse(input logic [NSRC-1:0] m);
    @(negedge clk); req = m; @(negedge clk); req = '0;
  endtask
  task automatic clr_done;
    for (int i = 0; i < NSRC; i++) dcnt[i] = 0;
  endtask

  // src, ctl, blk, cnt, sa, da, data, exp cnt, exp sa, exp da
  localparam logic [135:0] TV [7] = '{
    {8'd0,  8'h0C, 8'd4, 16'd5, 16'h0400, 16'h0500, 16'h005A, 16'd4, 16'h0401, 16'h0501},
    {8'd1,  8'h0D, 8'd4, 16'd3, 16'h0410, 16'h0510, 16'hBEEF, 16'd2, 16'h0412, 16'h0512},
    {8'd2,  8'h00, 8'd4, 16'd2, 16'h0420, 16'h0520, 16'h0033, 16'd1, 16'h0420, 16'h0520},
    {8'd7,  8'h05, 8'd4, 16'd1, 16'h0430, 16'h0530, 16'h1234, 16'd0, 16'h0432, 16'h0530},
    {8'd23, 8'h0E, 8'd3, 16'd1, 16'h0442, 16'h0542, 16'h0077, 16'd3, 16'h0440, 16'h0540},
    {8'd10, 8'h07, 8'd2, 16'd1, 16'h0452, 16'h0550, 16'hA5C3, 16'd2, 16'h0450, 16'h0550},
    {8'd4,  8'h0A, 8'd5, 16'd3, 16'h0460, 16'h0560, 16'h0044, 16'd2, 16'h0460, 16'h0561}
  };

  bit fin = 0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      total++; bad++; $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad); $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    clr_done;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cfg_rdata == 8'hFD, "R1", "base", cfg_rdata, 8'hFD);
    chk(done == '0, "R1", "done", done, 0);
    chk(!mem_rd && !mem_wr, "R1", "mem strobes", {mem_rd, mem_wr}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(cfg_rdata == 8'hFD, "R1", "base after release", cfg_rdata, 8'hFD);

    for (int t = 0; t < 7; t++) begin
      logic [7:0] k, c, b; logic [15:0] n, s, d, dat, en, es, ed, r; string tag; int edone;
      {k, c, b, n, s, d, dat, en, es, ed} = TV[t];
      r = 16'h0100 + 16'(k) * 16'h20;
      put_rec(r, c, b, n, s, d); put_vec(k, r); wr16(s, dat); wr16(d, 16'h0000);
      tag = c[1] ? "R7" : c[0] ? "R4" : (c[3:2] != 2'b11) ? "R5" : "R3";
      edone = (!c[1] && en == 0) ? 1 : 0;
      clr_done; pulse(NSRC'(1) << k); repeat (30) @(negedge clk);
      chk(rd16(r + 2) == en, tag, "count", rd16(r + 2), en);
      chk(rd16(r + 4) == es, tag, "src addr", rd16(r + 4), es);
      chk(rd16(r + 6) == ed, tag, "dst addr", rd16(r + 6), ed);
      if (c[0]) chk(rd16(d) == dat, "R2", "moved word", rd16(d), dat);
      else      chk(rd16(d) == {8'h00, dat[7:0]}, "R2", "moved byte", rd16(d), dat[7:0]);
      chk(dcnt[k] == edone, "R6", "done pulses", dcnt[k], edone);
    end

    // R8 chain of two records
    put_rec(16'h0600, 8'h1C, 8'd4, 16'd4, 16'h0470, 16'h0570);
    put_rec(16'h0608, 8'h0C, 8'd4, 16'd1, 16'h0471, 16'h0571);
    put_vec(12, 16'h0600);
    mem[16'h470] = 8'h61; mem[16'h471] = 8'h62;
    clr_done; pulse(NSRC'(1) << 12); repeat (40) @(negedge clk);
    chk(mem[16'h570] == 8'h61, "R8", "first unit", mem[16'h570], 8'h61);
    chk(mem[16'h571] == 8'h62, "R8", "chained unit", mem[16'h571], 8'h62);
    chk(rd16(16'h0602) == 16'd3, "R8", "first count", rd16(16'h0602), 3);
    chk(rd16(16'h060A) == 16'd0, "R8", "chained count", rd16(16'h060A), 0);
    chk(dcnt[12] == 1, "R8", "done after chain", dcnt[12], 1);

    // R9 two simultaneous requests into the same fixed destination
    put_rec(16'h0700, 8'h00, 8'd4, 16'd9, 16'h0480, 16'h0580);
    put_rec(16'h0710, 8'h00, 8'd4, 16'd9, 16'h0481, 16'h0580);
    put_vec(3, 16'h0700); put_vec(5, 16'h0710);
    mem[16'h480] = 8'h31; mem[16'h481] = 8'h35;
    pulse((NSRC'(1) << 3) | (NSRC'(1) << 5)); repeat (50) @(negedge clk);
    chk(mem[16'h580] == 8'h35, "R9", "last writer", mem[16'h580], 8'h35);
    chk(rd16(16'h0702) == 16'd8, "R9", "src3 count", rd16(16'h0702), 8);
    chk(rd16(16'h0712) == 16'd8, "R9", "src5 count", rd16(16'h0712), 8);

    // R10 base write while idle, then while busy
    @(negedge clk); cfg_we = 1; cfg_wdata = 8'hE0; @(negedge clk); cfg_we = 0;
    bval = 8'hE0;
    chk(cfg_rdata == 8'hE0, "R10", "idle write", cfg_rdata, 8'hE0);
    put_rec(16'h0720, 8'h0C, 8'd4, 16'd2, 16'h0490, 16'h0590);
    put_vec(6, 16'h0720); mem[16'h490] = 8'h9A;
    pulse(NSRC'(1) << 6); repeat (3) @(negedge clk);
    cfg_we = 1; cfg_wdata = 8'h22; @(negedge clk); cfg_we = 0;
    chk(cfg_rdata == 8'hE0, "R10", "busy write ignored", cfg_rdata, 8'hE0);
    repeat (30) @(negedge clk);
    chk(mem[16'h590] == 8'h9A, "R10", "new base used", mem[16'h590], 8'h9A);
    chk(rd16(16'h0722) == 16'd1, "R10", "count via new base", rd16(16'h0722), 1);

    fin = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule